// File: doc/BRIEF.md
# Dual-Channel Converter Output Controller

This block is the digital back end of a two-channel sampling converter. On every sample clock it takes one 12-bit offset-binary word from each channel, together with that channel's over-range and under-range flags. It presents the two words on two output buses, either in straight binary or in two's complement. A bus-swap select decides which channel appears on which bus. A single overflow flag is formed from the four range flags, and a delayed copy of channel B's clock is produced for downstream capture on its falling edge.

Each channel has its own shutdown and output-disable controls. Together they decode to three power states per channel: running, nap and sleep. A channel in nap or sleep releases its bus. After the channel returns to running, a per-channel recovery counter keeps its data-valid flag low. The nap count is short (100 clocks by default). The sleep count is long and configurable, and stands in for a wake-up of about a millisecond. Real tri-state pads are modelled by per-output drive-enable signals. Every registered output reflects the inputs sampled at the previous rising clock edge.

Top module: `dual_adc_out_ctrl`

## Requirements
- R1: The 2-bit `fmt_sel` code picks the format and the stabilizer flag. Codes 0 and 1 give straight binary. Codes 2 and 3 give two's complement, made by inverting the most significant data bit. `stab_on` is high for codes 1 and 2 and low for codes 0 and 3.
- R2: One `fmt_sel` value applies the same format to both buses in the same cycle.
- R3: With `mux_sel` high, `bus_a` carries channel A and `bus_b` carries channel B. With `mux_sel` low, the two are swapped. Each bus shows the sample taken at the previous rising edge.
- R4: While channel A is running, `ovf` is high one cycle after any of `a_ovr`, `a_und`, `b_ovr` or `b_und` is high, and low otherwise.
- R5: `ovf` and `ovf_drv` are low while channel A is in nap or sleep. `ovf_drv` is also low while `a_out_off` is high.
- R6: A channel runs when its shutdown input is low. It sleeps when shutdown and output-disable are both high, and naps when shutdown is high and output-disable is low. `bus_a_drv` / `bus_b_drv` is low while its own channel is in nap or sleep or has output-disable high.
- R7: After nap, the channel's valid flag rises exactly NAP_CYC (default 100) rising edges after the first edge that samples shutdown low.
- R8: After sleep, the channel's valid flag rises exactly SLEEP_CYC rising edges after the first edge that samples shutdown low.
- R9: The valid flag goes low in the cycle after a channel enters nap or sleep. Any re-entry restarts the full recovery count.
- R10: While channel B is running, `clk_out` equals `clkb_in` delayed by CLK_DLY rising edges and `clk_out_drv` is high. While channel B is in nap or sleep, both are low.
- R11: After reset, both channels are running and valid, both buses read 0 and are driven, and `ovf` and `clk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Format and stabilizer code |
| mux_sel | input | 1 | High: straight bus routing; low: swapped |
| a_samp | input | 12 | Channel A offset-binary sample |
| a_ovr | input | 1 | Channel A over range |
| a_und | input | 1 | Channel A under range |
| b_samp | input | 12 | Channel B offset-binary sample |
| b_ovr | input | 1 | Channel B over range |
| b_und | input | 1 | Channel B under range |
| a_shdn | input | 1 | Channel A shutdown request |
| a_out_off | input | 1 | Channel A output disable / sleep select |
| b_shdn | input | 1 | Channel B shutdown request |
| b_out_off | input | 1 | Channel B output disable / sleep select |
| clkb_in | input | 1 | Channel B clock to be delayed |
| bus_a | output | 12 | Output bus A data |
| bus_a_drv | output | 1 | Bus A drive enable |
| bus_b | output | 12 | Output bus B data |
| bus_b_drv | output | 1 | Bus B drive enable |
| ovf | output | 1 | Shared overflow flag |
| ovf_drv | output | 1 | Overflow drive enable |
| stab_on | output | 1 | Clock duty stabilizer enable |
| a_valid | output | 1 | Channel A data valid |
| b_valid | output | 1 | Channel B data valid |
| clk_out | output | 1 | Delayed channel B clock |
| clk_out_drv | output | 1 | Clock output drive enable |

## Verification
The routing and formatting path is driven with random samples under all four format codes and both `mux_sel` levels. This separates a missing swap, a swap tied to the wrong level, and an MSB inversion applied to only one bus. Random range flags, some on one channel and some on both, show whether each flag reaches `ovf`. Directed power sequences separate nap from sleep by their recovery lengths, and sample the valid flag one edge before and at the expected rise to catch off-by-one counts. A short re-nap in the middle of a recovery shows whether the counter reloads or resumes.

// File: rtl/adcout_pkg.sv
// Shared types and decode helpers for the dual-channel output controller.
// Assumes the format code is two bits: bit 1 picks two's complement.
package adcout_pkg;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_NAP   = 2'd1,
        PWR_SLEEP = 2'd2
    } pwr_t;

    // Two's complement is selected by the upper bit of the code.
    function automatic logic fmt_is_tc(input logic [1:0] code);
        return code[1];
    endfunction

    // Stabilizer is on for the two middle codes.
    function automatic logic fmt_stab(input logic [1:0] code);
        return code[1] ^ code[0];
    endfunction

endpackage

// File: rtl/adcout_fmt.sv
// Converts one offset-binary word to the selected output format.
// Assumes DW >= 2; two's complement is the MSB inverted.
module adcout_fmt #(
    parameter int DW = 12
) (
    input  logic [DW-1:0] raw,
    input  logic          to_tc,
    output logic [DW-1:0] fmt
);
    // Invert the sign position only when two's complement is requested.
    always_comb begin
        fmt         = raw;
        fmt[DW-1]   = raw[DW-1] ^ to_tc;
    end
endmodule

// File: rtl/adcout_pwr.sv
// Per-channel power state and wake-up recovery counter.
// Shutdown low = run; shutdown high with disable high = sleep, else nap.
// The counter is reloaded on every low-power cycle and counts down in run;
// valid is high only in run with the counter at zero.
module adcout_pwr #(
    parameter int NAP_CYC   = 100,
    parameter int SLEEP_CYC = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn,
    input  logic out_off,
    output logic awake,
    output logic valid
);
    import adcout_pkg::*;

    localparam int MAXC = (NAP_CYC > SLEEP_CYC) ? NAP_CYC : SLEEP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pwr_t          state;
    logic [CW-1:0] cnt;

    // Track the requested power state and load or run the recovery count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_RUN;
            cnt   <= '0;
        end else if (shdn) begin
            state <= out_off ? PWR_SLEEP : PWR_NAP;
            cnt   <= out_off ? CW'(SLEEP_CYC) : CW'(NAP_CYC);
        end else begin
            state <= PWR_RUN;
            if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign awake = (state == PWR_RUN);
    assign valid = awake && (cnt == '0);
endmodule

// File: rtl/adcout_clkdly.sv
// Delays a clock-like level by DLY sample-clock edges.
// Assumes the input changes no faster than the sample clock.
module adcout_clkdly #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (DLY == 0) begin : g_none
            assign dout = din;
        end else if (DLY == 1) begin : g_one
            logic r;
            // Single-stage delay register.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b0;
                else        r <= din;
            end
            assign dout = r;
        end else begin : g_chain
            logic [DLY-1:0] sr;
            // Shift the level through DLY stages.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[DLY-2:0], din};
            end
            assign dout = sr[DLY-1];
        end
    endgenerate
endmodule

// File: rtl/dual_adc_out_ctrl.sv
// Output stage of a two-channel converter: format select, bus swap,
// shared overflow, per-channel power states and a delayed clock output.
// Index 0 is channel A, index 1 channel B. Each bus's drive enable follows
// the power and disable controls of the channel of the same letter.
module dual_adc_out_ctrl #(
    parameter int DW        = 12,
    parameter int NAP_CYC   = 100,
    parameter int SLEEP_CYC = 1500,
    parameter int CLK_DLY   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt_sel,
    input  logic          mux_sel,
    input  logic [DW-1:0] a_samp,
    input  logic          a_ovr,
    input  logic          a_und,
    input  logic [DW-1:0] b_samp,
    input  logic          b_ovr,
    input  logic          b_und,
    input  logic          a_shdn,
    input  logic          a_out_off,
    input  logic          b_shdn,
    input  logic          b_out_off,
    input  logic          clkb_in,
    output logic [DW-1:0] bus_a,
    output logic          bus_a_drv,
    output logic [DW-1:0] bus_b,
    output logic          bus_b_drv,
    output logic          ovf,
    output logic          ovf_drv,
    output logic          stab_on,
    output logic          a_valid,
    output logic          b_valid,
    output logic          clk_out,
    output logic          clk_out_drv
);
    import adcout_pkg::*;

    localparam int NCH = 2;

    logic [NCH-1:0][DW-1:0] raw;
    logic [NCH-1:0][DW-1:0] fmtd;
    logic [NCH-1:0]         shdn_v, off_v, awake, valid;
    logic [NCH-1:0]         off_q;
    logic [DW-1:0]          bus_a_q, bus_b_q;
    logic                   ovf_q, stab_q, clk_dly;
    logic                   to_tc;

    assign raw[0]    = a_samp;
    assign raw[1]    = b_samp;
    assign shdn_v[0] = a_shdn;
    assign shdn_v[1] = b_shdn;
    assign off_v[0]  = a_out_off;
    assign off_v[1]  = b_out_off;
    assign to_tc     = fmt_is_tc(fmt_sel);

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            adcout_fmt #(.DW(DW)) u_fmt (
                .raw   (raw[ch]),
                .to_tc (to_tc),
                .fmt   (fmtd[ch])
            );
            adcout_pwr #(.NAP_CYC(NAP_CYC), .SLEEP_CYC(SLEEP_CYC)) u_pwr (
                .clk     (clk),
                .rst_n   (rst_n),
                .shdn    (shdn_v[ch]),
                .out_off (off_v[ch]),
                .awake   (awake[ch]),
                .valid   (valid[ch])
            );
        end
    endgenerate

    // Register routed data, the raw overflow, stabilizer and disable levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_a_q <= '0;
            bus_b_q <= '0;
            ovf_q   <= 1'b0;
            stab_q  <= 1'b0;
            off_q   <= '0;
        end else begin
            bus_a_q <= mux_sel ? fmtd[0] : fmtd[1];
            bus_b_q <= mux_sel ? fmtd[1] : fmtd[0];
            ovf_q   <= a_ovr | a_und | b_ovr | b_und;
            stab_q  <= fmt_stab(fmt_sel);
            off_q   <= off_v;
        end
    end

    adcout_clkdly #(.DLY(CLK_DLY)) u_clkdly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (clkb_in),
        .dout  (clk_dly)
    );

    assign bus_a       = bus_a_q;
    assign bus_b       = bus_b_q;
    assign bus_a_drv   = awake[0] && !off_q[0];
    assign bus_b_drv   = awake[1] && !off_q[1];
    assign ovf         = ovf_q && awake[0];
    assign ovf_drv     = awake[0] && !off_q[0];
    assign stab_on     = stab_q;
    assign a_valid     = valid[0];
    assign b_valid     = valid[1];
    assign clk_out     = clk_dly && awake[1];
    assign clk_out_drv = awake[1];
endmodule

// File: rtl/adcout_chk.sv
// Port-level property checker for dual_adc_out_ctrl, attached by bind.
// Every property looks one cycle back and only past a cycle out of reset.
module adcout_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    fmt_sel,
    input logic          mux_sel,
    input logic [DW-1:0] a_samp,
    input logic          a_ovr,
    input logic          a_und,
    input logic [DW-1:0] b_samp,
    input logic          b_ovr,
    input logic          b_und,
    input logic          a_shdn,
    input logic          a_out_off,
    input logic          b_shdn,
    input logic          b_out_off,
    input logic          clkb_in,
    input logic [DW-1:0] bus_a,
    input logic          bus_a_drv,
    input logic [DW-1:0] bus_b,
    input logic          bus_b_drv,
    input logic          ovf,
    input logic          ovf_drv,
    input logic          stab_on,
    input logic          a_valid,
    input logic          b_valid,
    input logic          clk_out,
    input logic          clk_out_drv
);
    AST_STAB_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stab_on == ($past(fmt_sel) == 2'd1 || $past(fmt_sel) == 2'd2))); // R1

    AST_TC_BOTH_BUSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mux_sel) && $past(fmt_sel[1]))
        |-> (bus_a[DW-1] != $past(a_samp[DW-1]) && bus_b[DW-1] != $past(b_samp[DW-1]))); // R2

    AST_SWAP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mux_sel) && $past(fmt_sel) == 2'd0)
        |-> (bus_a == $past(b_samp) && bus_b == $past(a_samp))); // R3

    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(a_shdn) && $past(a_ovr | a_und | b_ovr | b_und)) |-> ovf); // R4

    AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_shdn)) |-> (!ovf && !ovf_drv)); // R5

    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_shdn || b_out_off)) |-> !bus_b_drv); // R6

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_shdn)) |-> !a_valid); // R9

    AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_shdn)) |-> (!clk_out && !clk_out_drv)); // R10
endmodule

bind dual_adc_out_ctrl adcout_chk #(.DW(DW)) u_chk (.*);

// File: tb/dual_adc_out_ctrl_test.sv
// Self-checking bench: random routing/format phase, then directed power cases.
module dual_adc_out_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int NAP        = 100;
    localparam int SLP        = 1500;
    localparam int DLY        = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    fmt_sel = '0;
    logic          mux_sel = 1'b0;
    logic [DW-1:0] a_samp = '0, b_samp = '0;
    logic          a_ovr = 0, a_und = 0, b_ovr = 0, b_und = 0;
    logic          a_shdn = 0, a_out_off = 0, b_shdn = 0, b_out_off = 0;
    logic          clkb_in = 0;
    logic [DW-1:0] bus_a, bus_b;
    logic          bus_a_drv, bus_b_drv, ovf, ovf_drv, stab_on;
    logic          a_valid, b_valid, clk_out, clk_out_drv;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    dual_adc_out_ctrl #(.DW(DW), .NAP_CYC(NAP), .SLEEP_CYC(SLP), .CLK_DLY(DLY)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_fmt(input logic [DW-1:0] s, input logic [1:0] code);
        return code[1] ? {~s[DW-1], s[DW-2:0]} : s;
    endfunction

    function automatic logic exp_stab(input logic [1:0] code);
        return (code == 2'd1) || (code == 2'd2);
    endfunction

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] pa, pb;
        logic [1:0]    pf;
        logic          pm, pflag, poa, pob;
        logic          hist [0:7];
        for (int k = 0; k < 8; k++) hist[k] = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: state straight out of reset
        check("R11 a_valid", a_valid, 1);
        check("R11 b_valid", b_valid, 1);
        check("R11 bus_a", bus_a, 0);
        check("R11 bus_b", bus_b, 0);
        check("R11 ovf", ovf, 0);
        check("R11 clk_out", clk_out, 0);
        check("R11 bus_a_drv", bus_a_drv, 1);

        // Random phase: both channels running, disables toggled occasionally.
        void'($urandom(32'h5eed_c0de));
        pa = '0; pb = '0; pf = '0; pm = 0; pflag = 0; poa = 0; pob = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R1/R3 bus_a", bus_a, exp_fmt(pm ? pa : pb, pf));
                check("R2/R3 bus_b", bus_b, exp_fmt(pm ? pb : pa, pf));
                check("R1 stab_on", stab_on, exp_stab(pf));
                check("R4 ovf", ovf, pflag);
                check("R5 ovf_drv", ovf_drv, !poa);
                check("R6 bus_a_drv", bus_a_drv, !poa);
                check("R6 bus_b_drv", bus_b_drv, !pob);
                if (i > DLY) check("R10 clk_out", clk_out, hist[DLY-1]);
            end
            // Directed corners at the start, random afterwards.
            if (i < 8) begin
                a_samp = (i % 2) ? '1 : '0;
                b_samp = (i % 2) ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
                fmt_sel = 2'(i % 4);
                mux_sel = i[2];
            end else begin
                a_samp = DW'($urandom);
                b_samp = DW'($urandom);
                fmt_sel = 2'($urandom);
                mux_sel = 1'($urandom);
            end
            a_ovr = ($urandom % 8) == 0;
            a_und = ($urandom % 8) == 0;
            b_ovr = ($urandom % 8) == 0;
            b_und = ($urandom % 8) == 0;
            a_out_off = ($urandom % 10) == 0;
            b_out_off = ($urandom % 10) == 0;
            clkb_in = 1'($urandom);
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = clkb_in;
            pa = a_samp; pb = b_samp; pf = fmt_sel; pm = mux_sel;
            pflag = a_ovr | a_und | b_ovr | b_und;
            poa = a_out_off; pob = b_out_off;
        end

        // Output-disable alone: bus and flag released, channel still valid.
        a_out_off = 1; a_ovr = 1;
        @(negedge clk);
        check("R5 ovf_drv off", ovf_drv, 0);
        check("R6 bus_a_drv off", bus_a_drv, 0);
        check("R6 a_valid off", a_valid, 1);
        a_out_off = 0; b_out_off = 0;

        // Channel A nap: flag forced low, then recovery of NAP edges.
        a_shdn = 1; a_out_off = 0;
        repeat (5) @(negedge clk);
        check("R5 ovf in nap", ovf, 0);
        check("R5 ovf_drv in nap", ovf_drv, 0);
        check("R6 bus_a_drv nap", bus_a_drv, 0);
        check("R9 a_valid nap", a_valid, 0);
        a_shdn = 0; a_ovr = 0;
        repeat (NAP - 1) @(negedge clk);
        check("R7 a_valid early", a_valid, 0);
        @(negedge clk);
        check("R7 a_valid on time", a_valid, 1);

        // Re-nap mid recovery restarts the full count.
        a_shdn = 1;
        @(negedge clk);
        a_shdn = 0;
        repeat (50) @(negedge clk);
        a_shdn = 1;
        @(negedge clk);
        check("R9 a_valid renap", a_valid, 0);
        a_shdn = 0;
        repeat (NAP - 1) @(negedge clk);
        check("R9 a_valid restart early", a_valid, 0);
        @(negedge clk);
        check("R9 a_valid restart done", a_valid, 1);

        // Channel B sleep: clock output gated, long recovery.
        b_shdn = 1; b_out_off = 1; clkb_in = 1;
        repeat (4) @(negedge clk);
        check("R10 clk_out sleep", clk_out, 0);
        check("R10 clk_out_drv sleep", clk_out_drv, 0);
        check("R6 bus_b_drv sleep", bus_b_drv, 0);
        check("R6 a_valid unaffected", a_valid, 1);
        b_shdn = 0; b_out_off = 0;
        repeat (NAP) @(negedge clk);
        check("R8 b_valid not at nap count", b_valid, 0);
        repeat (SLP - NAP - 1) @(negedge clk);
        check("R8 b_valid early", b_valid, 0);
        @(negedge clk);
        check("R8 b_valid on time", b_valid, 1);
        check("R10 clk_out_drv run", clk_out_drv, 1);
        check("R10 clk_out run", clk_out, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule